// File: doc/BRIEF.md
# Selectable-Source 8-bit Event Counter

The block is an 8-bit up-counter whose advance is chosen by a 3-bit source select. The counter can be halted, can step on every system clock, or can step on one of four prescaled clock-enable strobes supplied from outside. It can also count edges of an asynchronous input pin. That pin first crosses into the system clock domain through a two-flop synchronizer clocked on the rising system edge. A history flop after the synchronizer finds the rising or falling edge, so pin transitions must stay at least one system-clock period apart.

When the count wraps from 255 to 0, a sticky overflow flag is set. Software clears the flag with a write-one strobe, and a wrap in the same cycle as a clear wins. The interrupt request is the flag gated by an enable mask. Software can load the counter directly. A load takes effect on the next clock edge and replaces that cycle's increment.

Top module: `tc8_timer`

## Requirements
- R1: After reset the count is 0, the overflow flag is 0 and the interrupt request is 0.
- R2: With select 3'b000 the count holds whatever the enables and the pin do.
- R3: With select 3'b001 the count rises by one on every system clock edge.
- R4: Selects 3'b010, 3'b011, 3'b100 and 3'b101 step the count only on edges where prescaler enable bit 0 (/8), bit 1 (/64), bit 2 (/256) or bit 3 (/1024) respectively is high, and the other enable bits are ignored.
- R5: With select 3'b111, a low-to-high pin change made between two clock edges increments the count on the third rising clock edge after the change and not before, and high-to-low changes are not counted.
- R6: With select 3'b110, a high-to-low pin change is counted on the third clock edge after the change, and low-to-high changes are not counted.
- R7: A step from 255 sets the count to 0 and sets the overflow flag on that same edge.
- R8: The overflow flag stays set until a clear strobe of one is applied, and the clear takes effect on the next edge.
- R9: When a wrap and a clear strobe happen on the same edge, the flag ends up set.
- R10: A counter write loads the written value on the next edge, suppresses that edge's increment, and raises no overflow even when the count was 255.
- R11: The interrupt request equals the overflow flag ANDed with the interrupt enable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_sel_i | input | 3 | Count source select |
| pre_en_i | input | 4 | Prescaled clock enables: /8, /64, /256, /1024 (bit 0 to bit 3) |
| ext_pin_i | input | 1 | Asynchronous external count input |
| cnt_wr_i | input | 1 | Counter load strobe |
| cnt_wdata_i | input | 8 | Value loaded by the strobe |
| ovf_clr_i | input | 1 | Write-one strobe that clears the overflow flag |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| cnt_o | output | 8 | Current count |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
A wrong synchronizer depth or wrong history state would move the counted edge off the third clock after a pin change, or would count the opposite edge. The count port shows either fault within three cycles. A select decode that picks the wrong enable would show as a wrong delta over a few cycles of held enables. A flag priority fault shows one edge after a wrap, as a clear flag where the flag should still be set. A load that fails to beat the increment shows as 0 instead of 255, or as a spurious flag, one edge after the write.

// File: rtl/tc8_pkg.sv
package tc8_pkg;

  typedef enum logic [2:0] {
    SRC_STOP     = 3'd0,
    SRC_SYS      = 3'd1,
    SRC_DIV8     = 3'd2,
    SRC_DIV64    = 3'd3,
    SRC_DIV256   = 3'd4,
    SRC_DIV1024  = 3'd5,
    SRC_EXT_FALL = 3'd6,
    SRC_EXT_RISE = 3'd7
  } src_e;

  localparam int unsigned PRE_BASE = 2;

  // true when a step from this value wraps to zero
  function automatic logic at_top(input logic [7:0] v);
    return &v;
  endfunction

  function automatic logic [7:0] step_count(input logic [7:0] v);
    return v + 8'd1;
  endfunction

endpackage

// File: rtl/tc8_edge_sync.sv
module tc8_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              hist_q;
  logic              synced;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= pin_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], pin_i};
    end
  endgenerate

  assign synced = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) hist_q <= 1'b0;
    else         hist_q <= synced;

  assign rise_o = synced & ~hist_q;
  assign fall_o = ~synced & hist_q;

  // R5
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  // R6
  fall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/tc8_tick_sel.sv
module tc8_tick_sel
  import tc8_pkg::*;
#(
  parameter int unsigned NUM_PRE = 4
) (
  input  logic [2:0]         sel_i,
  input  logic [NUM_PRE-1:0] pre_en_i,
  input  logic               ext_rise_i,
  input  logic               ext_fall_i,
  output logic               tick_o
);
  localparam int unsigned PRE_LAST = PRE_BASE + NUM_PRE - 1;

  src_e src;
  assign src = src_e'(sel_i);

  always_comb begin
    tick_o = 1'b0;
    unique case (src)
      SRC_STOP:     tick_o = 1'b0;
      SRC_SYS:      tick_o = 1'b1;
      SRC_EXT_FALL: tick_o = ext_fall_i;
      SRC_EXT_RISE: tick_o = ext_rise_i;
      default: begin
        for (int i = 0; i < NUM_PRE; i++)
          if (32'(sel_i) == PRE_BASE + i) tick_o = pre_en_i[i];
        if (32'(sel_i) > PRE_LAST) tick_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/tc8_count_core.sv
module tc8_count_core
  import tc8_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       clr_i,
  output logic [7:0] cnt_o,
  output logic       flag_o,
  output logic       wrap_o
);
  logic [7:0] cnt_q;
  logic       flag_q;

  assign wrap_o = tick_i & ~wr_i & at_top(cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (tick_i) cnt_q <= step_count(cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      flag_q <= 1'b0;
    else if (wrap_o)  flag_q <= 1'b1;
    else if (clr_i)   flag_q <= 1'b0;

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  // R7
  wrap_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (flag_o && cnt_o == 8'd0));
  // R8
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  // R9
  wrap_beats_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && clr_i) |=> flag_o);
  // R10
  write_loads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_o == $past(wdata_i));
endmodule

// File: rtl/tc8_timer.sv
module tc8_timer
  import tc8_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] src_sel_i,
  input  logic [3:0] pre_en_i,
  input  logic       ext_pin_i,
  input  logic       cnt_wr_i,
  input  logic [7:0] cnt_wdata_i,
  input  logic       ovf_clr_i,
  input  logic       ovf_ie_i,
  output logic [7:0] cnt_o,
  output logic       ovf_flag_o,
  output logic       irq_o
);
  logic ext_rise, ext_fall, tick, wrap;

  tc8_edge_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(ext_pin_i),
    .rise_o(ext_rise), .fall_o(ext_fall)
  );

  tc8_tick_sel #(.NUM_PRE(4)) u_sel (
    .sel_i(src_sel_i), .pre_en_i(pre_en_i),
    .ext_rise_i(ext_rise), .ext_fall_i(ext_fall), .tick_o(tick)
  );

  tc8_count_core u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .wr_i(cnt_wr_i),
    .wdata_i(cnt_wdata_i), .clr_i(ovf_clr_i), .cnt_o(cnt_o),
    .flag_o(ovf_flag_o), .wrap_o(wrap)
  );

  assign irq_o = ovf_flag_o & ovf_ie_i;

  // R2
  stop_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == 3'd0 && !cnt_wr_i) |=> $stable(cnt_o));
  // R3
  sys_steps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == 3'd1 && !cnt_wr_i) |=> cnt_o == $past(cnt_o) + 8'd1);
endmodule

// File: tb/tc8_timer_tb.sv
module tc8_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [3:0] pre = 4'h0;
  logic       pin = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic       clr = 1'b0;
  logic       ie = 1'b0;
  logic [7:0] cnt;
  logic       flag, irq;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  tc8_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_sel_i(sel), .pre_en_i(pre),
    .ext_pin_i(pin), .cnt_wr_i(wr), .cnt_wdata_i(wdata),
    .ovf_clr_i(clr), .ovf_ie_i(ie), .cnt_o(cnt), .ovf_flag_o(flag), .irq_o(irq)
  );

  // fields: select, enables, cycles, expected count
  localparam int NV = 9;
  localparam logic [18:0] VEC [NV] = '{
    {3'd1, 4'b0000, 4'd10, 8'd10},  // R3
    {3'd0, 4'b1111, 4'd8,  8'd0},   // R2
    {3'd2, 4'b0001, 4'd5,  8'd5},   // R4
    {3'd2, 4'b1110, 4'd5,  8'd0},   // R4
    {3'd3, 4'b0010, 4'd6,  8'd6},   // R4
    {3'd3, 4'b1101, 4'd4,  8'd0},   // R4
    {3'd4, 4'b0100, 4'd7,  8'd7},   // R4
    {3'd5, 4'b1000, 4'd4,  8'd4},   // R4
    {3'd5, 4'b0111, 4'd4,  8'd0}    // R4
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input logic [7:0] v);
    wr = 1'b1; wdata = v;
    step(1);
    wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    check("R1 count", cnt, 0);
    check("R1 flag", flag, 0);
    check("R1 irq", irq, 0);

    for (int v = 0; v < NV; v++) begin
      sel = VEC[v][18:16];
      pre = VEC[v][15:12];
      load(8'd0);
      step(int'(VEC[v][11:8]));
      check($sformatf("R2/R3/R4 vector %0d", v), cnt, int'(VEC[v][7:0]));
    end
    pre = 4'h0;

    // R5 rising pin mode
    sel = 3'd7; load(8'd0);
    pin = 1'b1; step(2);
    check("R5 not before third edge", cnt, 0);
    step(1);
    check("R5 counted on third edge", cnt, 1);
    pin = 1'b0; step(4);
    check("R5 falling ignored", cnt, 1);

    // R6 falling pin mode
    sel = 3'd6; load(8'd0);
    pin = 1'b1; step(4);
    check("R6 rising ignored", cnt, 0);
    pin = 1'b0; step(2);
    check("R6 not before third edge", cnt, 0);
    step(1);
    check("R6 counted on third edge", cnt, 1);

    // R7 / R11 wrap
    sel = 3'd1; ie = 1'b0; load(8'd254);
    check("R10 load value", cnt, 254);
    step(1);
    check("R7 no flag at 255", flag, 0);
    step(1);
    check("R7 wrapped count", cnt, 0);
    check("R7 flag set", flag, 1);
    check("R11 irq masked", irq, 0);
    ie = 1'b1; #1;
    check("R11 irq enabled", irq, 1);

    // R8 sticky and clear
    @(negedge clk);
    sel = 3'd0; step(3);
    check("R8 flag sticky", flag, 1);
    clr = 1'b1; step(1); clr = 1'b0;
    check("R8 flag cleared", flag, 0);
    check("R11 irq follows flag", irq, 0);

    // R9 wrap wins over clear
    sel = 3'd1; load(8'd255);
    clr = 1'b1; step(1); clr = 1'b0;
    check("R9 wrap count", cnt, 0);
    check("R9 flag kept", flag, 1);

    // R10 load suppresses increment and overflow
    clr = 1'b1; step(1); clr = 1'b0;
    check("R8 clear while counting", flag, 0);
    wr = 1'b1; wdata = 8'd255; step(2); wr = 1'b0;
    check("R10 no increment", cnt, 255);
    check("R10 no overflow", flag, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule